// File: doc/BRIEF.md
# Integer ALU with Condition Flags

This block is the integer execution stage of a 32-bit datapath. Each cycle it may receive an operation code, a source operand and a destination operand, qualified by a valid strobe. It computes an arithmetic, logical, shift or multiply result. On the next clock edge it registers that result together with a write-enable pulse. It also keeps a four-bit condition flag register: carry, zero, sign and overflow.

How the flags update depends on the operation. Compare is a subtraction whose result is discarded. Test is an AND whose result is discarded; it updates only zero and sign and clears carry and overflow. The address-calculation operation writes a sum but leaves every flag as it was. A shift by zero writes the unchanged destination and also leaves the flags alone. Multiplication keeps the low 32 bits of the product.

A small three-state controller tracks what the last edge captured. ST_IDLE means nothing was accepted. ST_WRITE means a result was registered, and `result_we` is high. ST_CHECK means only the flags were updated (compare or test). Every edge chooses the next state afresh from the incoming operation: a valid writing operation goes to ST_WRITE, a valid compare or test goes to ST_CHECK, and an idle cycle or an unassigned code goes to ST_IDLE. These transitions apply from any of the three states.

Top module: `int_exec_unit`

## Requirements
- R1: While reset is held and just after it, `result` is 0, `result_we` is 0 and `flags` is 0.
- R2: Opcodes are ADD 0, SUB 1, MUL 2, SHL 3, SAR 4, SHR 5, XOR 6, AND 7, OR 8, INC 9, DEC 10, NEG 11, NOT 12, CMP 13, TEST 14, ADDR 15. A valid writing operation presents its result on `result`, with `result_we` high for exactly the one cycle after the accepting edge.
- R3: `flags` bit 0 is carry, bit 1 zero, bit 2 sign, bit 3 overflow. ADD (dst+src) and INC (dst+1) set carry on a carry out of bit 31, zero when the result is 0, and sign from result bit 31. They set overflow when the operands share a sign that differs from the result's sign.
- R4: SUB (dst−src), DEC (dst−1) and NEG (0−dst) set carry when the minuend is below the subtrahend as unsigned numbers. They set overflow when the operands differ in sign and the result's sign differs from the minuend's. Zero and sign come from the result.
- R5: CMP sets the flags exactly as SUB of the same operands would, but does not assert `result_we`, and `result` keeps its previous value.
- R6: TEST sets zero and sign from dst AND src, clears carry and overflow, does not assert `result_we`, and leaves `result` unchanged.
- R7: XOR, AND and OR write the bitwise result, set zero and sign from it, and clear carry and overflow. NOT writes the complement of dst and leaves the flags unchanged.
- R8: Shifts take the count from src bits 4:0 and ignore the upper bits. They shift dst, with SAR filling from bit 31. Carry is the last bit shifted out, zero and sign come from the result, and overflow is cleared. A count of 0 writes dst unchanged and keeps all flags.
- R9: MUL writes the low 32 bits of dst×src, sets zero and sign from them, and clears carry and overflow.
- R10: ADDR writes dst+src and keeps all four flags unchanged.
- R11: A cycle with `op_valid` low, or carrying an unassigned opcode (16 to 31), leaves `result` and `flags` unchanged and does not assert `result_we`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Qualifies the operation on this cycle |
| op_code | input | 5 | Operation select |
| src_opnd | input | 32 | Source operand; low 5 bits are the shift count |
| dst_opnd | input | 32 | Destination operand, also the minuend |
| result | output | 32 | Registered result of the last writing operation |
| result_we | output | 1 | High for one cycle after a writing operation is accepted |
| flags | output | 4 | Condition flags {overflow, sign, zero, carry} |

## Verification
The hardest cases to reach are those where the flags must survive an operation: ADDR, NOT, a zero-count shift, an idle cycle or an unassigned opcode. A fault there shows only if the flags held before were non-zero and varied. The stimulus therefore sweeps every opcode across a grid of operand pairs that includes the sign boundaries, all-ones and small shift counts. In that grid, each flag-holding operation directly follows operations that left different carry, overflow and sign patterns behind. The bench carries its own running model of the flag register, so every such "no change" is compared against the specific values the previous operation left.

// File: rtl/iexu_pkg.sv
package iexu_pkg;

    localparam int OPW = 5;

    typedef enum logic [OPW-1:0] {
        OP_ADD  = 5'd0,
        OP_SUB  = 5'd1,
        OP_MUL  = 5'd2,
        OP_SHL  = 5'd3,
        OP_SAR  = 5'd4,
        OP_SHR  = 5'd5,
        OP_XOR  = 5'd6,
        OP_AND  = 5'd7,
        OP_OR   = 5'd8,
        OP_INC  = 5'd9,
        OP_DEC  = 5'd10,
        OP_NEG  = 5'd11,
        OP_NOT  = 5'd12,
        OP_CMP  = 5'd13,
        OP_TEST = 5'd14,
        OP_ADDR = 5'd15
    } op_e;

    // Packed so that carry sits at bit 0 and overflow at bit 3.
    typedef struct packed {
        logic ovf;
        logic sgn;
        logic zro;
        logic cry;
    } flags_t;

    typedef enum logic [1:0] {
        SH_LEFT,
        SH_LOGIC_R,
        SH_ARITH_R
    } sh_mode_e;

    typedef enum logic [1:0] {
        LG_XOR,
        LG_AND,
        LG_OR,
        LG_NOT
    } lg_sel_e;

endpackage

// File: rtl/iexu_addsub.sv
module iexu_addsub #(
    parameter int W = 32
) (
    input  logic [W-1:0] opa,
    input  logic [W-1:0] opb,
    input  logic         do_sub,
    output logic [W-1:0] sum,
    output logic         carry_borrow,
    output logic         ovf
);
    localparam int MSB = W - 1;

    logic [W-1:0] b_eff;
    logic [W:0]   wide;

    always_comb begin
        b_eff = do_sub ? ~opb : opb;
        wide  = {1'b0, opa} + {1'b0, b_eff} + {{W{1'b0}}, do_sub};
        sum   = wide[W-1:0];
        // subtraction reports a borrow, i.e. the inverted carry out
        carry_borrow = do_sub ? ~wide[W] : wide[W];
        ovf   = (opa[MSB] == b_eff[MSB]) && (wide[MSB] != opa[MSB]);
    end

endmodule

// File: rtl/iexu_shift.sv
module iexu_shift
    import iexu_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0]         din,
    input  logic [$clog2(W)-1:0] cnt,
    input  sh_mode_e             mode,
    output logic [W-1:0]         dout,
    output logic                 cout
);
    localparam int SW = $clog2(W);

    logic        fill;
    logic [W:0]  lv [0:SW];
    logic [W:0]  rv [0:SW];

    assign fill  = (mode == SH_ARITH_R) ? din[W-1] : 1'b0;
    assign lv[0] = {1'b0, din};
    assign rv[0] = {din, 1'b0};

    for (genvar k = 0; k < SW; k++) begin : g_stage
        localparam int SH = 1 << k;
        assign lv[k+1] = cnt[k] ? (lv[k] << SH) : lv[k];
        assign rv[k+1] = cnt[k] ? {{SH{fill}}, rv[k][W:SH]} : rv[k];
    end

    always_comb begin
        unique case (mode)
            SH_LEFT: begin
                dout = lv[SW][W-1:0];
                cout = lv[SW][W];
            end
            SH_LOGIC_R, SH_ARITH_R: begin
                dout = rv[SW][W:1];
                cout = rv[SW][0];
            end
            default: begin
                dout = din;
                cout = 1'b0;
            end
        endcase
    end

    // R8
    always_comb begin
        if (cnt == '0) begin
            zero_count_pass_chk: assert (dout == din);
        end
    end

endmodule

// File: rtl/iexu_logic.sv
module iexu_logic
    import iexu_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [W-1:0] opa,
    input  logic [W-1:0] opb,
    input  lg_sel_e      sel,
    output logic [W-1:0] res
);
    always_comb begin
        unique case (sel)
            LG_XOR:  res = opa ^ opb;
            LG_AND:  res = opa & opb;
            LG_OR:   res = opa | opb;
            LG_NOT:  res = ~opa;
            default: res = opa;
        endcase
    end

endmodule

// File: rtl/int_exec_unit.sv
module int_exec_unit
    import iexu_pkg::*;
#(
    parameter int W = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 op_valid,
    input  logic [OPW-1:0]       op_code,
    input  logic [W-1:0]         src_opnd,
    input  logic [W-1:0]         dst_opnd,
    output logic [W-1:0]         result,
    output logic                 result_we,
    output logic [3:0]           flags
);
    localparam int SW = $clog2(W);

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_WRITE,
        ST_CHECK
    } st_e;

    st_e      state_q, state_d;
    op_e      op;
    flags_t   flags_q, fl_d;
    logic [W-1:0] res_q, res_d;
    logic     wr_d, chk_d;

    // shared adder/subtractor
    logic [W-1:0] as_a, as_b, as_sum;
    logic         as_sub, as_cb, as_ovf;
    // shifter
    sh_mode_e     sh_mode;
    logic [W-1:0] sh_res;
    logic         sh_cout, sh_zero_cnt;
    // logic unit
    lg_sel_e      lg_sel;
    logic [W-1:0] lg_res;
    // multiplier, low half only
    logic [W-1:0] prod;

    assign op = op_e'(op_code);

    always_comb begin
        as_a   = dst_opnd;
        as_b   = src_opnd;
        as_sub = 1'b0;
        unique case (op)
            OP_SUB, OP_CMP: as_sub = 1'b1;
            OP_INC: as_b = {{(W-1){1'b0}}, 1'b1};
            OP_DEC: begin
                as_b   = {{(W-1){1'b0}}, 1'b1};
                as_sub = 1'b1;
            end
            OP_NEG: begin
                as_a   = '0;
                as_b   = dst_opnd;
                as_sub = 1'b1;
            end
            default: ;
        endcase
    end

    iexu_addsub #(.W(W)) u_addsub (
        .opa          (as_a),
        .opb          (as_b),
        .do_sub       (as_sub),
        .sum          (as_sum),
        .carry_borrow (as_cb),
        .ovf          (as_ovf)
    );

    always_comb begin
        unique case (op)
            OP_SAR:  sh_mode = SH_ARITH_R;
            OP_SHR:  sh_mode = SH_LOGIC_R;
            default: sh_mode = SH_LEFT;
        endcase
    end

    assign sh_zero_cnt = (src_opnd[SW-1:0] == '0);

    iexu_shift #(.W(W)) u_shift (
        .din  (dst_opnd),
        .cnt  (src_opnd[SW-1:0]),
        .mode (sh_mode),
        .dout (sh_res),
        .cout (sh_cout)
    );

    always_comb begin
        unique case (op)
            OP_XOR:  lg_sel = LG_XOR;
            OP_OR:   lg_sel = LG_OR;
            OP_NOT:  lg_sel = LG_NOT;
            default: lg_sel = LG_AND;
        endcase
    end

    iexu_logic #(.W(W)) u_logic (
        .opa (dst_opnd),
        .opb (src_opnd),
        .sel (lg_sel),
        .res (lg_res)
    );

    assign prod = dst_opnd * src_opnd;

    // operation decode: result, flag policy and class
    always_comb begin
        res_d = as_sum;
        fl_d  = flags_q;
        wr_d  = 1'b0;
        chk_d = 1'b0;
        unique case (op)
            OP_ADD, OP_SUB, OP_INC, OP_DEC, OP_NEG: begin
                wr_d = 1'b1;
                fl_d = '{ovf: as_ovf, sgn: as_sum[W-1], zro: ~|as_sum, cry: as_cb};
            end
            OP_CMP: begin
                chk_d = 1'b1;
                fl_d  = '{ovf: as_ovf, sgn: as_sum[W-1], zro: ~|as_sum, cry: as_cb};
            end
            OP_MUL: begin
                res_d = prod;
                wr_d  = 1'b1;
                fl_d  = '{ovf: 1'b0, sgn: prod[W-1], zro: ~|prod, cry: 1'b0};
            end
            OP_SHL, OP_SAR, OP_SHR: begin
                res_d = sh_res;
                wr_d  = 1'b1;
                if (!sh_zero_cnt) begin
                    fl_d = '{ovf: 1'b0, sgn: sh_res[W-1], zro: ~|sh_res, cry: sh_cout};
                end
            end
            OP_XOR, OP_AND, OP_OR: begin
                res_d = lg_res;
                wr_d  = 1'b1;
                fl_d  = '{ovf: 1'b0, sgn: lg_res[W-1], zro: ~|lg_res, cry: 1'b0};
            end
            OP_NOT: begin
                res_d = lg_res;
                wr_d  = 1'b1;
            end
            OP_TEST: begin
                chk_d = 1'b1;
                fl_d  = '{ovf: 1'b0, sgn: lg_res[W-1], zro: ~|lg_res, cry: 1'b0};
            end
            OP_ADDR: begin
                wr_d = 1'b1;
            end
            default: ;
        endcase
    end

    // next-state selection
    always_comb begin
        state_d = ST_IDLE;
        if (op_valid) begin
            if (wr_d)       state_d = ST_WRITE;
            else if (chk_d) state_d = ST_CHECK;
            else            state_d = ST_IDLE;
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // output registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_q   <= '0;
            flags_q <= '0;
        end else if (op_valid) begin
            if (wr_d) res_q <= res_d;
            flags_q <= fl_d;
        end
    end

    assign result    = res_q;
    assign result_we = (state_q == ST_WRITE);
    assign flags     = flags_q;

    // R2
    we_follows_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        result_we |-> $past(op_valid));

    // R11
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(op_valid) |-> ($stable(flags) && $stable(result) && !result_we));

    // R5
    compare_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(op_valid) && ($past(op_code) == OP_CMP || $past(op_code) == OP_TEST))
        |-> (!result_we && $stable(result)));

    // R6
    test_clears_co_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(op_valid) && $past(op_code) == OP_TEST) |-> (!flags[0] && !flags[3]));

    // R10
    addr_keeps_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(op_valid) && $past(op_code) == OP_ADDR) |-> ($stable(flags) && result_we));

endmodule

// File: tb/int_exec_unit_tb.sv
`timescale 1ns/1ps
module int_exec_unit_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_valid = 1'b0;
    logic [4:0]  op_code = '0;
    logic [31:0] src_opnd = '0;
    logic [31:0] dst_opnd = '0;
    logic [31:0] result;
    logic        result_we;
    logic [3:0]  flags;

    int n_chk = 0;
    int n_fail = 0;

    logic [31:0] exp_res = '0;
    logic [3:0]  exp_fl = '0;

    always #4 clk = ~clk;

    int_exec_unit #(.W(32)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .op_valid  (op_valid),
        .op_code   (op_code),
        .src_opnd  (src_opnd),
        .dst_opnd  (dst_opnd),
        .result    (result),
        .result_we (result_we),
        .flags     (flags)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] opval(input int i);
        case (i)
            0: return 32'h0000_0000;
            1: return 32'h0000_0001;
            2: return 32'h0000_0002;
            3: return 32'h7fff_ffff;
            4: return 32'h8000_0000;
            5: return 32'hffff_ffff;
            6: return 32'h8000_0001;
            7: return 32'h0000_001f;
            8: return 32'h1234_5678;
            default: return 32'hffff_fffe;
        endcase
    endfunction

    function automatic string req_of(input int op);
        case (op)
            0, 9:       return "R3";
            1, 10, 11:  return "R4";
            13:         return "R5";
            14:         return "R6";
            6, 7, 8, 12: return "R7";
            3, 4, 5:    return "R8";
            2:          return "R9";
            15:         return "R10";
            default:    return "R11";
        endcase
    endfunction

    // flags as {ovf, sgn, zro, cry}
    function automatic logic [3:0] zs(input logic [31:0] v, input logic c, input logic o);
        return {o, v[31], (v == 32'd0), c};
    endfunction

    task automatic model(input int op, input logic [31:0] s, input logic [31:0] d,
                         output logic we);
        logic [32:0] t;
        logic [31:0] v;
        int n;
        we = 1'b0;
        n = int'(s[4:0]);
        case (op)
            0, 9: begin
                logic [31:0] b;
                b = (op == 9) ? 32'd1 : s;
                t = {1'b0, d} + {1'b0, b};
                v = t[31:0];
                exp_res = v; we = 1'b1;
                exp_fl = zs(v, t[32], (d[31] == b[31]) && (v[31] != d[31]));
            end
            1, 10, 11, 13: begin
                logic [31:0] a, b;
                a = (op == 11) ? 32'd0 : d;
                b = (op == 10) ? 32'd1 : ((op == 11) ? d : s);
                v = a - b;
                exp_fl = zs(v, a < b, (a[31] != b[31]) && (v[31] != a[31]));
                if (op != 13) begin exp_res = v; we = 1'b1; end
            end
            2: begin
                logic [63:0] p;
                p = {32'd0, d} * {32'd0, s};
                exp_res = p[31:0]; we = 1'b1;
                exp_fl = zs(p[31:0], 1'b0, 1'b0);
            end
            3, 4, 5: begin
                we = 1'b1;
                if (n == 0) exp_res = d;
                else begin
                    logic c;
                    if (op == 3) begin v = d << n; c = d[32-n]; end
                    else if (op == 5) begin v = d >> n; c = d[n-1]; end
                    else begin v = 32'($signed(d) >>> n); c = d[n-1]; end
                    exp_res = v;
                    exp_fl = zs(v, c, 1'b0);
                end
            end
            6, 7, 8: begin
                v = (op == 6) ? (d ^ s) : ((op == 7) ? (d & s) : (d | s));
                exp_res = v; we = 1'b1;
                exp_fl = zs(v, 1'b0, 1'b0);
            end
            12: begin exp_res = ~d; we = 1'b1; end
            14: exp_fl = zs(d & s, 1'b0, 1'b0);
            15: begin exp_res = d + s; we = 1'b1; end
            default: ;
        endcase
    endtask

    task automatic do_op(input int op, input logic [31:0] s, input logic [31:0] d);
        logic we;
        @(negedge clk);
        op_valid = 1'b1;
        op_code  = 5'(op);
        src_opnd = s;
        dst_opnd = d;
        model(op, s, d, we);
        @(negedge clk);
        op_valid = 1'b0;
        check(req_of(op), "result_we", {31'd0, result_we}, {31'd0, we});
        check(req_of(op), "result", result, exp_res);
        check(req_of(op), "flags", {28'd0, flags}, {28'd0, exp_fl});
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_fail++;
        n_chk++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        // R1 reset state while held and after release
        check("R1", "result", result, 32'd0);
        check("R1", "result_we", {31'd0, result_we}, 32'd0);
        check("R1", "flags", {28'd0, flags}, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "flags after release", {28'd0, flags}, 32'd0);

        // R2 one-cycle write pulse
        do_op(0, 32'd5, 32'd7);
        @(negedge clk);
        check("R2", "result_we pulse ends", {31'd0, result_we}, 32'd0);
        check("R2", "result held", result, 32'd12);

        // R11 idle cycle with garbage inputs: nothing moves
        op_code = 5'd0; src_opnd = 32'hdead_beef; dst_opnd = 32'h1;
        @(negedge clk);
        check("R11", "idle result", result, exp_res);
        check("R11", "idle flags", {28'd0, flags}, {28'd0, exp_fl});

        // sweep: every opcode over the operand grid
        for (int op = 0; op < 18; op++) begin
            for (int i = 0; i < 10; i++) begin
                for (int j = 0; j < 10; j++) begin
                    do_op(op, opval(i), opval(j));
                end
            end
        end

        // interleave flag-holding ops after flag-setting ones (R8, R10, R7)
        for (int i = 0; i < 10; i++) begin
            do_op(1, opval(i), opval(9 - i));
            do_op(15, opval(i), opval(i));
            do_op(3, 32'hffff_ffe0, opval(i));
            do_op(12, opval(i), opval(i));
            do_op(20, opval(i), opval(i));
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule